// File: doc/BRIEF.md
# Overlay Plane Register Bank

This block holds the programming state of one overlay display plane behind a 32-bit register bus. It covers control, position, size, stride, linear and tiled start offsets, surface base, colour-key bounds and mask, constant alpha and gamma. Each register exists twice. Software writes and reads a pending copy. The display engine sees only a live copy.

A write to the surface base register arms a commit. On the next vertical-blank strobe, every pending register moves into the live set in one cycle, and the commit flag drops. Live state is decoded into plane fields for the fetch engine:

- enable, gamma enable, pixel format, source keying and YUV byte order;
- the tiled flag;
- x/y origin;
- width/height in pixels;
- the start offset.

Software disables the plane by clearing enable and then writing the surface base, for example with zero. The change reaches the engine at the following blank.

Top module: `ovl_plane_regs`

## Requirements
- R1: With `rst_n` low at a clock edge, all pending and live registers become zero, `commit_pending` becomes 0, and the plane reads back as disabled.
- R2: A write lands in the pending register at its byte offset, and a read of that offset returns the pending value in the same cycle. The offsets are: control 0x00, linear offset 0x04, stride 0x08, position 0x0C, size 0x10, key low 0x14, key mask 0x18, surface 0x1C, key high 0x20, tile offset 0x24, alpha 0x28, gamma 0x74. Any other offset, including one that is not a multiple of 4, reads zero, and writes to it are dropped.
- R3: A write to the surface register (0x1C) sets `commit_pending` from the next cycle on.
- R4: Without an armed commit, neither register writes nor a `vblank` pulse change any live output.
- R5: A `vblank` pulse while a commit is armed copies every pending register to the live set in that cycle and clears `commit_pending`. The new live values appear one cycle after the pulse.
- R6: Live control decodes as follows: bit 31 gives `plane_en`, bit 30 gives `gamma_en`, bits 29:26 give `pix_fmt`, bit 22 gives `ckey_en`, bits 17:16 give `yuv_order`, and bit 10 gives `tiled`.
- R7: The live position register gives `pos_y` from bits 31:16 and `pos_x` from bits 15:0.
- R8: The size register holds height-1 in bits 31:16 and width-1 in bits 15:0. The outputs `height` and `width` are the field value plus one, 17 bits wide.
- R9: `fetch_ofs` equals the live tile offset register when `tiled` is 1, and the live linear offset register otherwise.
- R10: A second surface write before the blank replaces the pending values. One blank then delivers the latest writes.
- R11: Clearing the enable bit and then writing 0 to the surface register gives `plane_en` = 0 and `surf_live` = 0 after the next blank.
- R12: A surface write in the same cycle as a blank does not enter that transfer. The transfer uses the earlier pending values, the commit stays armed, and the next blank delivers the new write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Write byte offset |
| wr_data | input | 32 | Write data |
| rd_addr | input | ADDR_W | Read byte offset |
| rd_data | output | 32 | Pending value at `rd_addr` |
| vblank | input | 1 | Vertical-blank strobe |
| commit_pending | output | 1 | Surface write seen, transfer not yet done |
| surf_live | output | 32 | Live surface base |
| plane_en | output | 1 | Live plane enable |
| gamma_en | output | 1 | Live gamma enable |
| pix_fmt | output | 4 | Live pixel format code |
| ckey_en | output | 1 | Live source colour key enable |
| yuv_order | output | 2 | Live YUV byte order |
| tiled | output | 1 | Live tiled surface flag |
| pos_x | output | 16 | Live x origin |
| pos_y | output | 16 | Live y origin |
| width | output | 17 | Live width in pixels |
| height | output | 17 | Live height in pixels |
| fetch_ofs | output | 32 | Start offset selected by the tiled flag |

## Verification
The assertions check the commit handshake on every cycle:

- a surface write arms the commit;
- a blank with no surface write beside it disarms it;
- the live set stays frozen unless an armed blank occurs;
- after an armed blank, the live set equals the prior pending set.

Only the bench scenarios can show the rest:

- the offset map, including holes and misaligned offsets;
- the field decode of control, position and size;
- the choice between tiled and linear offset;
- a surface write that lands on the blank itself;
- the disable sequence.

// File: rtl/ovl_pkg.sv
package ovl_pkg;
  localparam int REG_W = 32;
  localparam int NREG  = 12;
  localparam int HALF  = REG_W / 2;

  typedef enum logic [3:0] {
    RI_CTRL, RI_LINOFF, RI_STRIDE, RI_POS, RI_SIZE, RI_KLOW,
    RI_KMASK, RI_SURF, RI_KHIGH, RI_TILEOFF, RI_ALPHA, RI_GAMMA
  } reg_idx_t;

  // dense words 0..10, gamma sits apart at byte 0x74
  localparam int LAST_DENSE = 10;
  localparam int GAMMA_WORD = 'h74 / 4;

  // control bit positions decoded by the fetch engine
  localparam int CB_EN    = 31;
  localparam int CB_GAMMA = 30;
  localparam int CB_FMT   = 26;
  localparam int CB_CKEY  = 22;
  localparam int CB_ORDER = 16;
  localparam int CB_TILE  = 10;

  typedef struct packed {
    logic     hit;
    reg_idx_t idx;
  } dec_t;

  function automatic dec_t map_offset(input logic [15:0] byte_ofs);
    dec_t r;
    int   word;
    r.hit = 1'b0;
    r.idx = RI_CTRL;
    word  = int'(byte_ofs[15:2]);
    if (byte_ofs[1:0] == 2'b00) begin
      if (word <= LAST_DENSE) begin
        r.hit = 1'b1;
        r.idx = reg_idx_t'(word[3:0]);
      end else if (word == GAMMA_WORD) begin
        r.hit = 1'b1;
        r.idx = RI_GAMMA;
      end
    end
    return r;
  endfunction

  function automatic logic [HALF:0] len_from_field(input logic [HALF-1:0] f);
    return {1'b0, f} + {{HALF{1'b0}}, 1'b1};
  endfunction

  function automatic logic [REG_W-1:0] pick_start(input logic is_tiled,
                                                  input logic [REG_W-1:0] lin,
                                                  input logic [REG_W-1:0] tile);
    return is_tiled ? tile : lin;
  endfunction
endpackage

// File: rtl/ovl_addr_decode.sv
module ovl_addr_decode
  import ovl_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output reg_idx_t          idx
);
  localparam int PAD = 16 - ADDR_W;
  dec_t d;

  generate
    if (PAD > 0) begin : g_pad
      always_comb d = map_offset({{PAD{1'b0}}, addr});
    end else begin : g_nopad
      always_comb d = map_offset(addr[15:0]);
    end
  endgenerate

  assign hit = d.hit;
  assign idx = d.idx;
endmodule

// File: rtl/ovl_shadow_regs.sv
module ovl_shadow_regs
  import ovl_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_hit,
  input  reg_idx_t                    wr_idx,
  input  logic [REG_W-1:0]            wr_data,
  input  logic                        vblank,
  output logic [NREG-1:0][REG_W-1:0]  pend,
  output logic [NREG-1:0][REG_W-1:0]  live,
  output logic                        armed
);
  logic [NREG-1:0] we;
  logic            surf_wr;
  logic            commit_fire;

  generate
    for (genvar g = 0; g < NREG; g++) begin : g_we
      assign we[g] = wr_hit && (int'(wr_idx) == g);
    end
  endgenerate

  assign surf_wr     = we[RI_SURF];
  assign commit_fire = vblank && armed;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= '0;
      live <= '0;
    end else begin
      for (int i = 0; i < NREG; i++) begin
        if (we[i])       pend[i] <= wr_data;
        if (commit_fire) live[i] <= pend[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)           armed <= 1'b0;
    else if (surf_wr)     armed <= 1'b1;
    else if (commit_fire) armed <= 1'b0;
  end

  assert_surf_arms_R3: assert property (@(posedge clk) disable iff (!rst_n)
    surf_wr |=> armed);

  assert_blank_disarms_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_fire && !surf_wr) |=> !armed);

  assert_live_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_fire |=> $stable(live));

  assert_live_takes_pend_R5: assert property (@(posedge clk) disable iff (!rst_n)
    commit_fire |=> (live == $past(pend)));
endmodule

// File: rtl/ovl_field_unpack.sv
module ovl_field_unpack
  import ovl_pkg::*;
(
  input  logic [REG_W-1:0] ctrl,
  input  logic [REG_W-1:0] pos,
  input  logic [REG_W-1:0] size,
  input  logic [REG_W-1:0] lin_ofs,
  input  logic [REG_W-1:0] tile_ofs,
  output logic             plane_en,
  output logic             gamma_en,
  output logic [3:0]       pix_fmt,
  output logic             ckey_en,
  output logic [1:0]       yuv_order,
  output logic             tiled,
  output logic [HALF-1:0]  pos_x,
  output logic [HALF-1:0]  pos_y,
  output logic [HALF:0]    width,
  output logic [HALF:0]    height,
  output logic [REG_W-1:0] fetch_ofs
);
  assign plane_en  = ctrl[CB_EN];
  assign gamma_en  = ctrl[CB_GAMMA];
  assign pix_fmt   = ctrl[CB_FMT +: 4];
  assign ckey_en   = ctrl[CB_CKEY];
  assign yuv_order = ctrl[CB_ORDER +: 2];
  assign tiled     = ctrl[CB_TILE];
  assign pos_x     = pos[HALF-1:0];
  assign pos_y     = pos[REG_W-1:HALF];
  assign width     = len_from_field(size[HALF-1:0]);
  assign height    = len_from_field(size[REG_W-1:HALF]);
  assign fetch_ofs = pick_start(tiled, lin_ofs, tile_ofs);
endmodule

// File: rtl/ovl_plane_regs.sv
module ovl_plane_regs
  import ovl_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [31:0]       rd_data,
  input  logic              vblank,
  output logic              commit_pending,
  output logic [31:0]       surf_live,
  output logic              plane_en,
  output logic              gamma_en,
  output logic [3:0]        pix_fmt,
  output logic              ckey_en,
  output logic [1:0]        yuv_order,
  output logic              tiled,
  output logic [15:0]       pos_x,
  output logic [15:0]       pos_y,
  output logic [16:0]       width,
  output logic [16:0]       height,
  output logic [31:0]       fetch_ofs
);
  logic                       wr_hit_raw, rd_hit;
  reg_idx_t                   wr_idx, rd_idx;
  logic [NREG-1:0][REG_W-1:0] pend, live;

  ovl_addr_decode #(.ADDR_W(ADDR_W)) u_wdec (
    .addr(wr_addr), .hit(wr_hit_raw), .idx(wr_idx));
  ovl_addr_decode #(.ADDR_W(ADDR_W)) u_rdec (
    .addr(rd_addr), .hit(rd_hit), .idx(rd_idx));

  ovl_shadow_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_hit(wr_en && wr_hit_raw), .wr_idx(wr_idx),
    .wr_data(wr_data), .vblank(vblank), .pend(pend), .live(live),
    .armed(commit_pending));

  assign rd_data   = rd_hit ? pend[rd_idx] : '0;
  assign surf_live = live[RI_SURF];

  ovl_field_unpack u_unpack (
    .ctrl(live[RI_CTRL]), .pos(live[RI_POS]), .size(live[RI_SIZE]),
    .lin_ofs(live[RI_LINOFF]), .tile_ofs(live[RI_TILEOFF]),
    .plane_en(plane_en), .gamma_en(gamma_en), .pix_fmt(pix_fmt),
    .ckey_en(ckey_en), .yuv_order(yuv_order), .tiled(tiled),
    .pos_x(pos_x), .pos_y(pos_y), .width(width), .height(height),
    .fetch_ofs(fetch_ofs));

  assert_disarm_needs_blank_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(commit_pending) |-> $past(vblank));
endmodule

// File: tb/ovl_plane_regs_test.sv
module ovl_plane_regs_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [7:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        vblank = 1'b0;
  logic        commit_pending;
  logic [31:0] surf_live;
  logic        plane_en, gamma_en, ckey_en, tiled;
  logic [3:0]  pix_fmt;
  logic [1:0]  yuv_order;
  logic [15:0] pos_x, pos_y;
  logic [16:0] width, height;
  logic [31:0] fetch_ofs;

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  always #4 clk = ~clk;

  ovl_plane_regs uut (.*);

  localparam int NV = 12;
  localparam logic [7:0]  V_ADDR [NV] = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h10, 8'h14,
                                          8'h18, 8'h1C, 8'h20, 8'h24, 8'h28, 8'h74};
  localparam logic [31:0] V_DATA [NV] = '{32'hE442_0000, 32'h0000_1A00, 32'h0000_2000,
                                          32'h0123_0456, 32'h00EF_013F, 32'h0010_2030,
                                          32'h00FF_FF00, 32'h0010_0000, 32'h0080_9000,
                                          32'h0008_0010, 32'h0000_00C0, 32'h1234_5678};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic blank();
    @(negedge clk); vblank = 1'b1;
    @(negedge clk); vblank = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    rd_addr = a; #1; d = rd_data;
  endtask

  task automatic report();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired");
      report();
    end
  end

  initial begin
    logic [31:0] r;
    logic [31:0] c;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 plane_en", {31'b0, plane_en}, 0);
    chk("R1 commit", {31'b0, commit_pending}, 0);
    chk("R1 surf_live", surf_live, 0);
    rst_n = 1'b1;

    // R2 table: write each register then read back pending copy
    for (int i = 0; i < NV; i++) bus_wr(V_ADDR[i], V_DATA[i]);
    for (int i = 0; i < NV; i++) begin
      rd(V_ADDR[i], r);
      chk($sformatf("R2 readback %h", V_ADDR[i]), r, V_DATA[i]);
    end
    // R2 holes and misaligned offsets
    bus_wr(8'h2C, 32'hDEAD_BEEF);
    bus_wr(8'h76, 32'hCAFE_F00D);
    rd(8'h2C, r); chk("R2 hole read", r, 0);
    rd(8'h76, r); chk("R2 misaligned read", r, 0);
    rd(8'h28, r); chk("R2 neighbour intact", r, V_DATA[10]);
    rd(8'h74, r); chk("R2 gamma intact", r, V_DATA[11]);

    // R3 armed; R4 live untouched before blank
    chk("R3 armed", {31'b0, commit_pending}, 1);
    chk("R4 pos before blank", {pos_y, pos_x}, 0);
    chk("R4 surf before blank", surf_live, 0);

    // R5 transfer
    blank();
    chk("R5 disarmed", {31'b0, commit_pending}, 0);
    chk("R5 surf_live", surf_live, V_DATA[7]);
    // R6 control decode
    c = V_DATA[0];
    chk("R6 en", {31'b0, plane_en}, {31'b0, c[31]});
    chk("R6 gamma", {31'b0, gamma_en}, {31'b0, c[30]});
    chk("R6 fmt", {28'b0, pix_fmt}, {28'b0, c[29:26]});
    chk("R6 ckey", {31'b0, ckey_en}, {31'b0, c[22]});
    chk("R6 order", {30'b0, yuv_order}, {30'b0, c[17:16]});
    chk("R6 tiled", {31'b0, tiled}, 0);
    // R7 position
    chk("R7 x", {16'b0, pos_x}, 32'h456);
    chk("R7 y", {16'b0, pos_y}, 32'h123);
    // R8 size minus one
    chk("R8 width", {15'b0, width}, 32'h140);
    chk("R8 height", {15'b0, height}, 32'hF0);
    // R9 linear when not tiled
    chk("R9 linear", fetch_ofs, V_DATA[1]);

    // R4 blank with nothing armed
    bus_wr(8'h0C, 32'h0001_0001);
    blank();
    chk("R4 unarmed blank", {pos_y, pos_x}, 32'h0123_0456);

    // R9 tiled selects tile offset
    bus_wr(8'h00, V_DATA[0] | 32'h0000_0400);
    bus_wr(8'h1C, 32'h0020_0000);
    blank();
    chk("R9 tiled flag", {31'b0, tiled}, 1);
    chk("R9 tile offset", fetch_ofs, V_DATA[9]);

    // R10 second surface write overwrites
    bus_wr(8'h0C, 32'h0002_0003);
    bus_wr(8'h1C, 32'h0030_0000);
    bus_wr(8'h0C, 32'h0004_0005);
    bus_wr(8'h1C, 32'h0040_0000);
    blank();
    chk("R10 pos latest", {pos_y, pos_x}, 32'h0004_0005);
    chk("R10 surf latest", surf_live, 32'h0040_0000);

    // R12 surface write coinciding with blank
    bus_wr(8'h0C, 32'h0006_0007);
    bus_wr(8'h1C, 32'h0050_0000);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 8'h1C; wr_data = 32'h0060_0000; vblank = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; vblank = 1'b0;
    chk("R12 surf old", surf_live, 32'h0050_0000);
    chk("R12 pos", {pos_y, pos_x}, 32'h0006_0007);
    chk("R12 still armed", {31'b0, commit_pending}, 1);
    blank();
    chk("R12 surf new", surf_live, 32'h0060_0000);

    // R11 disable sequence
    rd(8'h00, r);
    bus_wr(8'h00, r & 32'h7FFF_FFFF);
    chk("R11 still on before surf", {31'b0, plane_en}, 1);
    bus_wr(8'h1C, 32'h0);
    blank();
    chk("R11 disabled", {31'b0, plane_en}, 0);
    chk("R11 surf zero", surf_live, 0);

    // R1 mid-run reset
    bus_wr(8'h1C, 32'h0070_0000);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); @(negedge clk);
    chk("R1 reset disarm", {31'b0, commit_pending}, 0);
    rd(8'h0C, r); chk("R1 reset pending", r, 0);
    chk("R1 reset live pos", {pos_y, pos_x}, 0);
    chk("R1 reset width", {15'b0, width}, 1);

    done = 1;
    report();
  end
endmodule